// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two component predictors. The first is a per-branch history predictor. A small set of history registers, selected by the low branch-address bits, records each branch's own recent outcomes. The selected history is XORed with the address to pick a 2-bit counter. The second is a shared-history predictor. One history register records the outcomes of all branches, and it is XORed with the address to pick a counter in a second table. A third table of 2-bit counters, indexed by address, learns for each branch which component to trust. The final prediction is the output of the component that this chooser selects.

Lookup is combinational from `lk_pc`. It returns the final prediction and both component predictions. The caller keeps both component predictions and returns them with the resolved outcome on the update port. The update port trains both counter tables and both histories. It also trains the chooser, but only when the two components disagreed. Update indices are recomputed from the history state current at the update. A lookup and an update may occur in the same cycle, and the lookup then reads the state from before that update.

Top module: `tournament_pred`

## Requirements
- R1: After reset, every direction counter holds 2'b01 (weakly not-taken), every chooser counter holds 2'b01 (weakly prefer the per-branch component), and all histories are zero. Every lookup therefore gives 0 on all three prediction outputs.
- R2: Every direction counter is a 2-bit saturating counter. It moves up by one on a taken outcome and down by one on a not-taken outcome, saturating at 2'b11 and 2'b00. A component predicts taken when its counter's upper bit is 1.
- R3: The per-branch component selects history register `pc[LSEL_W-1:0]`. It indexes its counter table with that history XOR `pc[LHIST_W-1:0]`.
- R4: The shared-history component indexes its counter table with the global history XOR `pc[GHIST_W-1:0]`.
- R5: The chooser counter at `pc[CHSEL_W-1:0]` changes only when `up_pred_local != up_pred_global`. It then steps up by one (saturating) if the global prediction matched the outcome, and down by one (saturating) otherwise.
- R6: On each update, the selected per-branch history and the global history both shift left by one, with the resolved outcome entering at bit 0.
- R7: A lookup in the same cycle as an update reads the state from before that update. The update becomes visible from the next cycle on.
- R8: `pred_final` equals `pred_global` when the chooser counter's upper bit is 1, and `pred_local` otherwise.
- R9: When `up_valid` is 0, no counter and no history changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Branch address bits for the lookup |
| pred_final | output | 1 | Chooser-selected prediction (1 = taken) |
| pred_local | output | 1 | Per-branch history component prediction |
| pred_global | output | 1 | Shared-history component prediction |
| up_valid | input | 1 | Update strobe |
| up_pc | input | PC_W | Branch address bits of the resolved branch |
| up_taken | input | 1 | Resolved outcome (1 = taken) |
| up_pred_local | input | 1 | Per-branch prediction made earlier for this branch |
| up_pred_global | input | 1 | Shared-history prediction made earlier for this branch |

## Verification
A lookup and an update can fall in the same cycle, and they may touch the same branch. The bench drives many cycles in which `lk_pc` and `up_pc` are equal, and it also applies updates that carry one address while another is looked up. Each expected prediction comes from a reference model read before its own update is applied. A design that forwards the new state into the lookup is flagged at once. So is a design that delays the update by an extra cycle.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_LOW = 2'b01;

  // Saturating step of a 2-bit counter toward 11 (up=1) or 00 (up=0).
  function automatic ctr2_t ctr2_step(input ctr2_t c, input logic up);
    if (up) return (c == 2'b11) ? c : c + 2'd1;
    else    return (c == 2'b00) ? c : c - 2'd1;
  endfunction

  // Shift a history left with the newest outcome entering at bit 0.
  function automatic logic [31:0] hist_push(input logic [31:0] h, input logic bit_in);
    return {h[30:0], bit_in};
  endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int IDX_W = 6,
  parameter tp_pkg::ctr2_t INIT = tp_pkg::CTR_WEAK_LOW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_dir,
  input  logic [IDX_W-1:0]  wr_idx,
  output tp_pkg::ctr2_t     wr_cur,
  input  logic              we,
  input  tp_pkg::ctr2_t     wr_val
);
  localparam int DEPTH = 1 << IDX_W;

  tp_pkg::ctr2_t mem [DEPTH];

  assign rd_dir = mem[rd_idx][1];
  assign wr_cur = mem[wr_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (we) begin
      mem[wr_idx] <= wr_val;
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int SEL_W  = 3,
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [HIST_W-1:0] rd_hist,
  input  logic [SEL_W-1:0]  up_sel,
  output logic [HIST_W-1:0] up_hist,
  input  logic              we,
  input  logic              taken
);
  localparam int DEPTH = 1 << SEL_W;

  logic [HIST_W-1:0] hist [DEPTH];

  assign rd_hist = hist[rd_sel];
  assign up_hist = hist[up_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist[i] <= '0;
    end else if (we) begin
      hist[up_sel] <= {hist[up_sel][HIST_W-2:0], taken};
    end
  end
endmodule

// File: rtl/tournament_pred.sv
module tournament_pred #(
  parameter int PC_W    = 6,
  parameter int LSEL_W  = 3,
  parameter int LHIST_W = 6,
  parameter int GHIST_W = 6,
  parameter int CHSEL_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_final,
  output logic            pred_local,
  output logic            pred_global,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken,
  input  logic            up_pred_local,
  input  logic            up_pred_global
);
  import tp_pkg::*;

  // Lookup-side named wires
  logic [LHIST_W-1:0] lk_lhist, lk_lidx;
  logic [GHIST_W-1:0] lk_gidx;
  logic [CHSEL_W-1:0] lk_cidx;
  logic               use_global;

  // Update-side named wires
  logic [LHIST_W-1:0] up_lhist, up_lidx;
  logic [GHIST_W-1:0] up_gidx;
  logic [CHSEL_W-1:0] up_cidx;
  ctr2_t              up_lctr, up_gctr, up_chctr;
  logic               comp_disagree;
  logic               ch_we;

  logic [GHIST_W-1:0] ghist;

  assign lk_lidx = lk_lhist ^ lk_pc[LHIST_W-1:0];
  assign lk_gidx = ghist ^ lk_pc[GHIST_W-1:0];
  assign lk_cidx = lk_pc[CHSEL_W-1:0];

  assign up_lidx = up_lhist ^ up_pc[LHIST_W-1:0];
  assign up_gidx = ghist ^ up_pc[GHIST_W-1:0];
  assign up_cidx = up_pc[CHSEL_W-1:0];

  assign comp_disagree = up_pred_local != up_pred_global;
  assign ch_we         = up_valid && comp_disagree;

  tp_hist_table #(.SEL_W(LSEL_W), .HIST_W(LHIST_W)) u_lhist (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_sel (lk_pc[LSEL_W-1:0]),
    .rd_hist(lk_lhist),
    .up_sel (up_pc[LSEL_W-1:0]),
    .up_hist(up_lhist),
    .we     (up_valid),
    .taken  (up_taken)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .INIT(CTR_WEAK_LOW)) u_lctr (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_idx(lk_lidx),
    .rd_dir(pred_local),
    .wr_idx(up_lidx),
    .wr_cur(up_lctr),
    .we    (up_valid),
    .wr_val(ctr2_step(up_lctr, up_taken))
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .INIT(CTR_WEAK_LOW)) u_gctr (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_idx(lk_gidx),
    .rd_dir(pred_global),
    .wr_idx(up_gidx),
    .wr_cur(up_gctr),
    .we    (up_valid),
    .wr_val(ctr2_step(up_gctr, up_taken))
  );

  // Chooser: upper bit set selects the shared-history component.
  tp_ctr_table #(.IDX_W(CHSEL_W), .INIT(CTR_WEAK_LOW)) u_chooser (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_idx(lk_cidx),
    .rd_dir(use_global),
    .wr_idx(up_cidx),
    .wr_cur(up_chctr),
    .we    (ch_we),
    .wr_val(ctr2_step(up_chctr, up_pred_global == up_taken))
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        ghist <= '0;
    else if (up_valid) ghist <= {ghist[GHIST_W-2:0], up_taken};
  end

  assign pred_final = use_global ? pred_global : pred_local;

endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int PC_W    = 6,
  parameter int GHIST_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PC_W-1:0]    lk_pc,
  input logic               pred_final,
  input logic               pred_local,
  input logic               pred_global,
  input logic               up_valid,
  input logic               up_taken,
  input logic               up_pred_local,
  input logic               up_pred_global,
  input logic               use_global,
  input logic [GHIST_W-1:0] ghist
);
  a_r6_ghist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> ghist == {$past(ghist[GHIST_W-2:0]), $past(up_taken)});

  a_r9_ghist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(ghist));

  a_r9_preds_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> ($stable(lk_pc) -> ($stable(pred_final) && $stable(pred_local) && $stable(pred_global))));

  a_r5_agree_keeps_choice: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (up_pred_local == up_pred_global)) |=> ($stable(lk_pc) -> $stable(use_global)));

  a_r8_final_from_component: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_final == pred_local) || (pred_final == pred_global));
endmodule

bind tournament_pred tp_checker #(.PC_W(PC_W), .GHIST_W(GHIST_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_pc         (lk_pc),
  .pred_final    (pred_final),
  .pred_local    (pred_local),
  .pred_global   (pred_global),
  .up_valid      (up_valid),
  .up_taken      (up_taken),
  .up_pred_local (up_pred_local),
  .up_pred_global(up_pred_global),
  .use_global    (use_global),
  .ghist         (ghist)
);

// File: tb/sim_tournament_pred.sv
`timescale 1ns/1ps
module sim_tournament_pred;
  localparam int PW = 6, LS = 3, LH = 6, GH = 6, CS = 6;

  logic clk = 0, rst_n = 0;
  logic [PW-1:0] lk_pc = '0, up_pc = '0;
  logic up_valid = 0, up_taken = 0, up_pl = 0, up_pg = 0;
  logic pred_final, pred_local, pred_global;

  always #2.5 clk = ~clk;

  tournament_pred #(.PC_W(PW), .LSEL_W(LS), .LHIST_W(LH), .GHIST_W(GH), .CHSEL_W(CS)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
    .pred_final(pred_final), .pred_local(pred_local), .pred_global(pred_global),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
    .up_pred_local(up_pl), .up_pred_global(up_pg));

  // Reference model state
  logic [LH-1:0] m_lhist [1<<LS];
  logic [1:0]    m_lctr  [1<<LH];
  logic [1:0]    m_gctr  [1<<GH];
  logic [1:0]    m_ch    [1<<CS];
  logic [GH-1:0] m_ghist;

  typedef struct { logic pl; logic pg; logic pf; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [1:0] sat(input logic [1:0] c, input logic up);
    if (up) return c == 3 ? 2'd3 : c + 2'd1;
    return c == 0 ? 2'd0 : c - 2'd1;
  endfunction

  function automatic logic mdl_pl(input logic [PW-1:0] pc);
    return m_lctr[m_lhist[pc[LS-1:0]] ^ pc[LH-1:0]][1];
  endfunction
  function automatic logic mdl_pg(input logic [PW-1:0] pc);
    return m_gctr[m_ghist ^ pc[GH-1:0]][1];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < (1<<LS); i++) m_lhist[i] = '0;
    for (int i = 0; i < (1<<LH); i++) m_lctr[i] = 2'b01;
    for (int i = 0; i < (1<<GH); i++) m_gctr[i] = 2'b01;
    for (int i = 0; i < (1<<CS); i++) m_ch[i] = 2'b01;
    m_ghist = '0;
  endtask

  // Driver: drive one cycle, push expected lookup result, then apply model update.
  task automatic step(input logic [PW-1:0] lpc, input logic uv, input logic [PW-1:0] upc,
                      input logic ut, input logic pl, input logic pg, input string tag);
    exp_t e;
    logic [LH-1:0] li;
    logic [GH-1:0] gi;
    @(negedge clk);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut; up_pl = pl; up_pg = pg;
    e.pl = mdl_pl(lpc);
    e.pg = mdl_pg(lpc);
    e.pf = m_ch[lpc[CS-1:0]][1] ? e.pg : e.pl;
    e.tag = tag;
    q.push_back(e);
    if (uv) begin
      li = m_lhist[upc[LS-1:0]] ^ upc[LH-1:0];
      gi = m_ghist ^ upc[GH-1:0];
      m_lctr[li] = sat(m_lctr[li], ut);
      m_gctr[gi] = sat(m_gctr[gi], ut);
      if (pl != pg) m_ch[upc[CS-1:0]] = sat(m_ch[upc[CS-1:0]], pg == ut);
      m_lhist[upc[LS-1:0]] = {m_lhist[upc[LS-1:0]][LH-2:0], ut};
      m_ghist = {m_ghist[GH-2:0], ut};
    end
  endtask

  // Same-pc lookup and update, feeding back the model's component predictions.
  task automatic train(input logic [PW-1:0] pc, input logic ut, input string tag);
    step(pc, 1'b1, pc, ut, mdl_pl(pc), mdl_pg(pc), tag);
  endtask

  // Monitor: compare away from the clock edges.
  initial begin
    forever begin
      @(negedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if ({pred_local, pred_global, pred_final} !== {e.pl, e.pg, e.pf}) begin
          errors++;
          $display("FAIL %s: local/global/final actual=%b%b%b expected=%b%b%b",
                   e.tag, pred_local, pred_global, pred_final, e.pl, e.pg, e.pf);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lfsr;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, several addresses, no update
    for (int p = 0; p < 6; p++) step(PW'(p * 11), 1'b0, '0, 1'b0, 1'b0, 1'b0, "R1");
    // R9: update fields set but strobe low; nothing may change
    step(PW'(5), 1'b0, PW'(5), 1'b1, 1'b0, 1'b1, "R9");
    step(PW'(5), 1'b0, PW'(5), 1'b1, 1'b0, 1'b1, "R9");
    step(PW'(5), 1'b0, '0, 1'b0, 1'b0, 1'b0, "R9");
    // R2 R3 R4 R6 R7: loop-like branch, taken 3 of 4, same-cycle lookup/update
    for (int i = 0; i < 16; i++) train(PW'(5), (i % 4) != 3, "R2 R3 R6 R7");
    // R2: saturation by a long taken run, then one not-taken
    for (int i = 0; i < 10; i++) train(PW'(20), 1'b1, "R2 R4");
    train(PW'(20), 1'b0, "R2");
    step(PW'(20), 1'b0, '0, 1'b0, 1'b0, 1'b0, "R2");
    // R5 R8: force chooser toward global, then check selection
    for (int i = 0; i < 3; i++) step(PW'(9), 1'b1, PW'(9), 1'b1, 1'b0, 1'b1, "R5 R8");
    step(PW'(9), 1'b0, '0, 1'b0, 1'b0, 1'b0, "R8");
    // R5: agreement leaves chooser alone
    for (int i = 0; i < 2; i++) step(PW'(9), 1'b1, PW'(9), 1'b0, 1'b1, 1'b1, "R5");
    step(PW'(9), 1'b0, '0, 1'b0, 1'b0, 1'b0, "R5");
    // R5: global wrong on disagreement moves back toward local
    for (int i = 0; i < 3; i++) step(PW'(9), 1'b1, PW'(9), 1'b0, 1'b0, 1'b1, "R5 R8");
    step(PW'(9), 1'b0, '0, 1'b0, 1'b0, 1'b0, "R8");
    // R7: update one branch while looking up another, and vice versa
    for (int i = 0; i < 8; i++) step(PW'(13), 1'b1, PW'(45), i[0], mdl_pl(PW'(45)), mdl_pg(PW'(45)), "R7 R3");
    // R3 R4 R6: pseudo-random streams with mixed addresses and outcomes
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      logic [PW-1:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = {lfsr[9:8], 1'b0, lfsr[2:0]};
      if (lfsr[5]) train(a, lfsr[11] | lfsr[3], "R3 R4 R6");
      else step(PW'(lfsr[15:10]), 1'b1, a, lfsr[7], mdl_pl(a), mdl_pg(a), "R4 R6 R7");
    end
    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule